// File: doc/BRIEF.md
# Level-Based Priority Interrupt Controller

This block sits between twelve peripheral interrupt request lines and a small 8-bit CPU. Each request line is qualified by its own enable bit and carries a 2-bit priority level. The levels live in three byte-wide level registers that the CPU writes over a simple register write port. Every cycle the controller finds the best enabled, pending request. It compares that request's level with the level of the routine the CPU is currently running. When the request outranks that routine, the controller raises an accept signal and a wake-up signal, and it shows the winning request's index and its two-byte vector table address pair.

A lower level value means a higher priority: 0 is the most urgent, 2 is the least urgent usable level, and 3 disables the line. The CPU's current level input is 3 during normal operation. When the CPU acknowledges an accepted interrupt, the controller latches the winner's index and level. The latched level is presented so the CPU can feed it back as its next current level. Selection and vector generation are purely combinational, so a new request is visible in the same cycle it arrives.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset every level field holds 3, `act_level` is 3, `act_idx` is 0, and `accept`, `wake`, `win_idx`, `vec_hi` and `vec_lo` are all 0.
- R2: A write with `reg_addr` 0, 1 or 2 loads the level fields of requests 0–3, 4–7 or 8–11 respectively. Request n uses bits [2(n mod 4)+1 : 2(n mod 4)] of that byte. A write with `reg_addr` 3 changes nothing.
- R3: A request line takes part only when both its `irq_req` and `irq_en` bits are 1. A line whose level is 3 is never accepted.
- R4: `accept` is 1 exactly when the best candidate's level is numerically smaller than `cpu_level`. A candidate with a level equal to `cpu_level` is held off, and `cpu_level` 0 blocks every request.
- R5: Among the candidates, the lowest level value wins. Among candidates of equal level, the lowest request index wins.
- R6: While `accept` is 1, `vec_hi` is 0xFFFA − 2n and `vec_lo` is 0xFFFB − 2n for winner n. While `accept` is 0, both are 0.
- R7: `wake` is 1 in exactly the cycles in which `accept` is 1.
- R8: `win_idx` gives the winner's index while `accept` is 1, and 0 otherwise.
- R9: When `ack` is 1 in a cycle with `accept` 1, the winner's index and level appear on `act_idx` and `act_level` after that clock edge. When `ack` arrives without `accept`, both outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 12 | Pending request per line |
| irq_en | input | 12 | Request output enable per line |
| reg_wr_en | input | 1 | Level register write strobe |
| reg_addr | input | 2 | Level register select |
| reg_wdata | input | 8 | Level register write data |
| cpu_level | input | 2 | Level of the running routine (3 = normal operation) |
| ack | input | 1 | CPU acknowledge of the accepted interrupt |
| accept | output | 1 | Winning request outranks the running routine |
| wake | output | 1 | Leave standby |
| win_idx | output | 4 | Index of the winning request |
| vec_hi | output | 16 | Address of the vector's upper byte |
| vec_lo | output | 16 | Address of the vector's lower byte |
| act_idx | output | 4 | Latched index of the acknowledged request |
| act_level | output | 2 | Latched level of the acknowledged request |

## Verification
The bench builds the block with its default parameters: twelve request lines, 8-bit level registers and a 2-bit register select. With these values there are three real level registers and one spare address, so a write to the unused address can be observed. The defaults also put all twelve vector address pairs within reach, down to 0xFFE4/0xFFE5. With every level programmed to 0, the bench walks the full vector range. It also covers tie-breaks within one level, the equal-level hold-off, and the case where the latched level is fed back as the current level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W = 2;
    localparam int VEC_W = 16;
    localparam logic [LVL_W-1:0] LVL_OFF    = 2'b11;
    localparam logic [VEC_W-1:0] VEC_TOP_HI = 16'hFFFA;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 12,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_IRQ-1:0][LVL_W-1:0] levels
);
    localparam int FIELDS   = DATA_W / LVL_W;
    localparam int NUM_REGS = (NUM_IRQ + FIELDS - 1) / FIELDS;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] bank;
    } regs_t;

    regs_t st_d, st_q;
    logic  addr_ok;

    assign addr_ok = int'(wr_addr) < NUM_REGS;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr_ok) begin
            st_d.bank[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_field
        assign levels[i] = st_q.bank[i / FIELDS][(i % FIELDS) * LVL_W +: LVL_W];
    end

    p_bad_addr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_ok) |=> $stable(levels));
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 12,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]            req,
    input  logic [NUM_IRQ-1:0]            en,
    input  logic [NUM_IRQ-1:0][LVL_W-1:0] levels,
    output logic                          found,
    output logic [IDX_W-1:0]              win_idx,
    output lvl_t                          win_lvl
);
    logic [NUM_IRQ-1:0] cand;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cand
        assign cand[i] = req[i] && en[i] && (levels[i] != LVL_OFF);
    end

    // Ascending scan with strict compare keeps the lowest index on ties.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = LVL_OFF;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!found || (levels[i] < win_lvl))) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = levels[i];
            end
        end
    end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map
    import irq_arb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             valid,
    input  logic [IDX_W-1:0] idx,
    output vec_t             hi,
    output vec_t             lo
);
    vec_t step;

    assign step = VEC_W'({idx, 1'b0});
    assign hi   = valid ? (VEC_TOP_HI - step)         : '0;
    assign lo   = valid ? (VEC_TOP_HI - step + 16'd1) : '0;
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 12,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [LVL_W-1:0]   cpu_level,
    input  logic               ack,
    output logic               accept,
    output logic               wake,
    output logic [IDX_W-1:0]   win_idx,
    output logic [VEC_W-1:0]   vec_hi,
    output logic [VEC_W-1:0]   vec_lo,
    output logic [IDX_W-1:0]   act_idx,
    output logic [LVL_W-1:0]   act_level
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        lvl_t             lvl;
    } act_t;

    logic [NUM_IRQ-1:0][LVL_W-1:0] levels;
    logic                          found;
    logic [IDX_W-1:0]              sel_idx;
    lvl_t                          sel_lvl;
    act_t                          act_d, act_q;

    irq_level_regs #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wr_addr(reg_addr),
        .wr_data(reg_wdata),
        .levels (levels)
    );

    irq_prio_select #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_sel (
        .req    (irq_req),
        .en     (irq_en),
        .levels (levels),
        .found  (found),
        .win_idx(sel_idx),
        .win_lvl(sel_lvl)
    );

    assign accept  = found && (sel_lvl < cpu_level);
    assign wake    = accept;
    assign win_idx = accept ? sel_idx : '0;

    irq_vec_map #(.IDX_W(IDX_W)) u_vec (
        .valid(accept),
        .idx  (sel_idx),
        .hi   (vec_hi),
        .lo   (vec_lo)
    );

    always_comb begin
        act_d = act_q;
        if (ack && accept) begin
            act_d.idx = sel_idx;
            act_d.lvl = sel_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q.idx <= '0;
            act_q.lvl <= LVL_OFF;
        end else begin
            act_q <= act_d;
        end
    end

    assign act_idx   = act_q.idx;
    assign act_level = act_q.lvl;

    p_accept_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (irq_req[win_idx] && irq_en[win_idx]));

    p_top_level_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level == 2'b00) |-> !accept);

    p_vec_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ((vec_lo == vec_hi + 16'd1) && !vec_hi[0]));

    p_idle_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> ((win_idx == '0) && (vec_hi == '0)));

    p_wake_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (|(irq_req & irq_en)));

    p_ack_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && accept) |=> ((act_idx == $past(win_idx)) && (act_level < $past(cpu_level))));

    p_ack_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && accept) |=> ($stable(act_idx) && $stable(act_level)));
endmodule

// File: tb/irq_level_arbiter_tb.sv
module irq_level_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] irq_req = '0;
    logic [11:0] irq_en = '0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [1:0]  cpu_level = 2'd3;
    logic        ack = 1'b0;
    logic        accept, wake;
    logic [3:0]  win_idx, act_idx;
    logic [15:0] vec_hi, vec_lo;
    logic [1:0]  act_level;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    irq_level_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cpu_level(cpu_level), .ack(ack), .accept(accept), .wake(wake),
        .win_idx(win_idx), .vec_hi(vec_hi), .vec_lo(vec_lo),
        .act_idx(act_idx), .act_level(act_level)
    );

    // Levels after programming: 0:2 1:1 2:1 3:0 4:3 5:2 6:0 7:1 8:2 9:2 10:1 11:0
    // Row: {req, en, cpu_level, exp_accept, exp_idx}
    localparam logic [30:0] TV [14] = '{
        {12'h001, 12'hFFF, 2'd3, 1'b1, 4'd0},   // R4 normal op accepts level 2
        {12'h006, 12'hFFF, 2'd3, 1'b1, 4'd1},   // R5 tie -> lower index
        {12'h00F, 12'hFFF, 2'd3, 1'b1, 4'd3},   // R5 lowest level wins
        {12'h848, 12'hFFF, 2'd3, 1'b1, 4'd3},   // R5 three-way tie at level 0
        {12'h010, 12'hFFF, 2'd3, 1'b0, 4'd0},   // R3 level 3 never accepted
        {12'h006, 12'hFFF, 2'd1, 1'b0, 4'd0},   // R4 equal level held off
        {12'h006, 12'hFFF, 2'd2, 1'b1, 4'd1},   // R4 outranks running routine
        {12'h008, 12'hFF7, 2'd3, 1'b0, 4'd0},   // R3 disabled line ignored
        {12'h808, 12'hFF7, 2'd3, 1'b1, 4'd11},  // R3 disabled winner skipped
        {12'h300, 12'hFFF, 2'd3, 1'b1, 4'd8},   // R5 tie at level 2
        {12'h300, 12'hFFF, 2'd2, 1'b0, 4'd0},   // R4 equal level held off
        {12'h400, 12'hFFF, 2'd2, 1'b1, 4'd10},  // R4 level 1 under 2
        {12'h0A0, 12'hFFF, 2'd3, 1'b1, 4'd7},   // R5 level 1 over level 2
        {12'h040, 12'hFFF, 2'd0, 1'b0, 4'd0}    // R4 cpu level 0 blocks all
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic apply(input logic [11:0] r, input logic [11:0] e, input logic [1:0] c);
        @(negedge clk);
        irq_req = r; irq_en = e; cpu_level = c;
        #2;
    endtask

    task automatic chk_win(input string tag, input logic exp_acc, input logic [3:0] exp_idx);
        logic [15:0] eh;
        eh = exp_acc ? 16'hFFFA - 16'(exp_idx) * 16'd2 : 16'h0;
        chk({tag, " accept"}, 32'(accept), 32'(exp_acc));
        chk({tag, " R7 wake"}, 32'(wake), 32'(exp_acc));
        chk({tag, " R8 win_idx"}, 32'(win_idx), 32'(exp_acc ? exp_idx : 4'd0));
        chk({tag, " R6 vec_hi"}, 32'(vec_hi), 32'(eh));
        chk({tag, " R6 vec_lo"}, 32'(vec_lo), 32'(exp_acc ? eh + 16'd1 : 16'h0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state; all levels at 3 so nothing is accepted (R3)
        apply(12'hFFF, 12'hFFF, 2'd3);
        chk_win("R1 reset", 1'b0, 4'd0);
        chk("R1 act_level", 32'(act_level), 32'd3);
        chk("R1 act_idx", 32'(act_idx), 32'd0);

        // R2 write to spare address 3 changes no level
        wr(2'd3, 8'h00);
        apply(12'hFFF, 12'hFFF, 2'd3);
        chk_win("R2 spare address", 1'b0, 4'd0);

        wr(2'd0, 8'h16);
        wr(2'd1, 8'h4B);
        wr(2'd2, 8'h1A);

        foreach (TV[i]) begin
            apply(TV[i][30:19], TV[i][18:7], TV[i][6:5]);
            chk_win($sformatf("table row %0d", i), TV[i][4], TV[i][3:0]);
        end

        // R9 acknowledge latches winner index and level
        @(negedge clk);
        irq_req = 12'h008; irq_en = 12'hFFF; cpu_level = 2'd3; ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        #2;
        chk("R9 act_idx load", 32'(act_idx), 32'd3);
        chk("R9 act_level load", 32'(act_level), 32'd0);

        // R9 acknowledge without accept leaves latch alone
        @(negedge clk);
        irq_req = 12'h000; ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        #2;
        chk("R9 act_idx hold", 32'(act_idx), 32'd3);
        chk("R9 act_level hold", 32'(act_level), 32'd0);

        // R4 latched level fed back as current level blocks level-0 request
        apply(12'h040, 12'hFFF, act_level);
        chk_win("R4 nested hold-off", 1'b0, 4'd0);

        // R6 full vector sweep with every level at 0
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        for (int n = 0; n < 12; n++) begin
            apply(12'(1 << n), 12'hFFF, 2'd3);
            chk_win($sformatf("R6 sweep irq %0d", n), 1'b1, 4'(n));
        end

        // R2 field position: top field of register 2 belongs to request 11
        wr(2'd2, 8'hC0);
        apply(12'h800, 12'hFFF, 2'd3);
        chk_win("R2 field irq11 off", 1'b0, 4'd0);
        apply(12'h400, 12'hFFF, 2'd3);
        chk_win("R2 field irq10 kept", 1'b1, 4'd10);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule